// File: doc/BRIEF.md
# Command/Response Half-Duplex Serial Master

This block is a serial master for a three-wire command/response link with a chip select. Each byte written into its transmit queue starts one frame. The frame drives the 8-bit command out on the data-out pin, most significant bit first. It then spends one serial clock idle so the remote device can decode the command. After that it clocks in a reply whose length is programmable from 4 to 32 bits, and it places the reply word in a receive queue. While no frame is active, the serial clock rests low, chip select rests high and the data-out pin is low.

The serial clock is the system clock divided by an even, programmable ratio. Chip select falls half a serial period before the first rising edge. If more commands are queued when a reply finishes, chip select stays low and the next command follows straight on. If the receive queue is full when a reply completes, the reply is discarded and a sticky overrun flag is raised.

Top module: `mw_master`

## Requirements
- R1: After reset and whenever no frame is active, `sclk` is 0, `cs_n` is 1 and `mosi` is 0.
- R2: When `cs_n` falls, `mosi` already carries bit 7 of the oldest queued command. The 8 command bits appear MSB first. Each bit changes only while `sclk` is low and is stable across the rising edge that follows.
- R3: A half serial period is `max(half_period,1)` system clock cycles. Every `sclk` edge, including the first rise after `cs_n` falls, comes exactly one half period after the previous edge or chip-select event.
- R4: The 9th rising edge of a frame is a wait clock: `mosi` is 0 there and `miso` is not sampled.
- R5: The reply length is `resp_len` clamped into 4..32 and latched at frame start. A frame has 9 + length rising edges.
- R6: Reply bits are sampled from `miso` on rising edges 10 onward, first bit as MSB. The word in `rx_data` is right-aligned and zero-extended.
- R7: With no further command queued, `cs_n` rises one full serial period after the last rising edge. The reply is in the receive queue in that same cycle.
- R8: With a further command queued, `cs_n` stays low. At the falling edge after the reply's last bit, `mosi` carries the next command's MSB and the finished word enters the receive queue.
- R9: A reply that completes while the receive queue is full is dropped and the queue is left as it was. `overrun` then reads 1 until reset.
- R10: No frame starts while the transmit queue is empty.
- R11: Commands go out in push order and replies are popped in completion order. Both queues are show-ahead, and a push into a full queue is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_push | input | 1 | Write `tx_data` into the command queue |
| tx_data | input | 8 | Command byte |
| tx_full | output | 1 | Command queue full |
| rx_pop | input | 1 | Remove the head reply word |
| rx_data | output | 32 | Head reply word (show-ahead) |
| rx_empty | output | 1 | Reply queue empty |
| resp_len | input | 6 | Reply length in bits, clamped to 4..32 |
| half_period | input | DIV_W | System cycles per half serial period (0 acts as 1) |
| overrun | output | 1 | Sticky: a reply was dropped |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Every serial event is due a fixed number of system cycles after the previous one: a clock edge or chip-select rise comes exactly one half period later. A chip-select fall follows within two cycles of a push into an empty queue. The reply word is visible in the receive queue in the same cycle as the chip-select rise or chain edge that completes it. A slave model on the falling system-clock edge counts cycles between events and compares each count with the programmed half period. It drives each reply bit one half period ahead of the rising edge that samples it, so every pin and queue check lands one half cycle after the register that produces the value. A sweep covers half periods 0 to 3 against reply lengths inside and outside 4..32. Chained batches and an overrun batch follow.

// File: rtl/mw_pkg.sv
package mw_pkg;
    localparam int CMD_W    = 8;
    localparam int MIN_RESP = 4;
    localparam int MAX_RESP = 32;
    localparam int LEN_W    = 6;
    localparam int EDGE_W   = $clog2(CMD_W + 1 + MAX_RESP + 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_STOP
    } mw_state_e;

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] v);
        if (v < LEN_W'(MIN_RESP))      return LEN_W'(MIN_RESP);
        else if (v > LEN_W'(MAX_RESP)) return LEN_W'(MAX_RESP);
        else                           return v;
    endfunction
endpackage

// File: rtl/mw_fifo.sv
module mw_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] count;
    } fifo_st_t;

    fifo_st_t q, d;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full  = (q.count == CW'(DEPTH));
    assign empty = (q.count == '0);
    assign dout  = mem_q[q.rptr];

    always_comb begin
        d       = q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) d.wptr = step(q.wptr);
        if (do_pop)  d.rptr = step(q.rptr);
        case ({do_push, do_pop})
            2'b10:   d.count = q.count + CW'(1);
            2'b01:   d.count = q.count - CW'(1);
            default: d.count = q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[q.wptr] <= din;
    end

    assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        q.count <= CW'(DEPTH));

    assert_full_push_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (q.count == CW'(DEPTH)));
endmodule

// File: rtl/mw_divider.sv
module mw_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_in,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] half;
    } div_st_t;

    div_st_t q, d;

    always_comb begin
        d    = q;
        tick = 1'b0;
        if (!run) begin
            d.cnt  = '0;
            d.half = (half_in == '0) ? DIV_W'(1) : half_in;
        end else begin
            tick  = (q.cnt == q.half - DIV_W'(1));
            d.cnt = tick ? '0 : q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{cnt: '0, half: DIV_W'(1)};
        else        q <= d;
    end

    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $past(tick) && q.half > DIV_W'(1)) |-> !tick);

    assert_half_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> $stable(q.half));
endmodule

// File: rtl/mw_engine.sv
module mw_engine
    import mw_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                tx_valid,
    input  logic [CMD_W-1:0]    tx_byte,
    output logic                tx_pop,
    input  logic                rx_full,
    output logic                rx_push,
    output logic [MAX_RESP-1:0] rx_word,
    input  logic [LEN_W-1:0]    resp_len,
    output logic                run,
    output logic                overrun,
    output logic                sclk,
    output logic                cs_n,
    output logic                mosi,
    input  logic                miso
);
    localparam logic [EDGE_W-1:0] WAIT_EDGE = EDGE_W'(CMD_W + 1);

    typedef struct packed {
        mw_state_e            state;
        logic                 sclk;
        logic                 cs_n;
        logic                 mosi;
        logic [EDGE_W-1:0]    edges;
        logic [CMD_W-1:0]     cmd_sh;
        logic [MAX_RESP-1:0]  rx_sh;
        logic [LEN_W-1:0]     rlen;
        logic                 overrun;
    } eng_st_t;

    eng_st_t q, d;
    logic want_push;
    logic [EDGE_W-1:0] last_edge;
    logic [EDGE_W-1:0] next_edge;

    assign last_edge = WAIT_EDGE + EDGE_W'(q.rlen);
    assign next_edge = q.edges + EDGE_W'(1);

    always_comb begin
        d         = q;
        tx_pop    = 1'b0;
        want_push = 1'b0;
        rx_push   = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (tx_valid) begin
                    tx_pop   = 1'b1;
                    d.state  = ST_RUN;
                    d.cs_n   = 1'b0;
                    d.sclk   = 1'b0;
                    d.cmd_sh = tx_byte;
                    d.mosi   = tx_byte[CMD_W-1];
                    d.edges  = '0;
                    d.rx_sh  = '0;
                    d.rlen   = clamp_len(resp_len);
                end
            end
            ST_RUN: begin
                if (tick) begin
                    if (!q.sclk) begin
                        d.sclk  = 1'b1;
                        d.edges = next_edge;
                        if (next_edge > WAIT_EDGE)
                            d.rx_sh = {q.rx_sh[MAX_RESP-2:0], miso};
                    end else begin
                        d.sclk = 1'b0;
                        if (q.edges < EDGE_W'(CMD_W)) begin
                            d.cmd_sh = q.cmd_sh << 1;
                            d.mosi   = d.cmd_sh[CMD_W-1];
                        end else begin
                            d.mosi = 1'b0;
                        end
                        if (q.edges == last_edge) begin
                            if (tx_valid) begin
                                want_push = 1'b1;
                                tx_pop    = 1'b1;
                                d.cmd_sh  = tx_byte;
                                d.mosi    = tx_byte[CMD_W-1];
                                d.edges   = '0;
                                d.rx_sh   = '0;
                                d.rlen    = clamp_len(resp_len);
                            end else begin
                                d.state = ST_STOP;
                            end
                        end
                    end
                end
            end
            ST_STOP: begin
                if (tick) begin
                    d.state   = ST_IDLE;
                    d.cs_n    = 1'b1;
                    want_push = 1'b1;
                end
            end
            default: d.state = ST_IDLE;
        endcase
        if (want_push) begin
            if (rx_full) d.overrun = 1'b1;
            else         rx_push   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.cs_n  <= 1'b1;
            q.rlen  <= LEN_W'(MIN_RESP);
        end else begin
            q <= d;
        end
    end

    assign rx_word = q.rx_sh;
    assign run     = (q.state != ST_IDLE);
    assign overrun = q.overrun;
    assign sclk    = q.sclk;
    assign cs_n    = q.cs_n;
    assign mosi    = q.mosi;

    assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE) |-> (q.cs_n && !q.sclk && !q.mosi));

    assert_clock_inside_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q.sclk |-> !q.cs_n);

    assert_mosi_hold_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sclk && $past(q.sclk)) |-> $stable(q.mosi));

    assert_wait_clock_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sclk && q.edges == WAIT_EDGE) |-> !q.mosi);

    assert_edge_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.edges <= last_edge) && (q.rlen >= LEN_W'(MIN_RESP)) && (q.rlen <= LEN_W'(MAX_RESP)));

    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q.overrun |=> q.overrun);

    assert_overrun_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.overrun) |-> $past(rx_full));
endmodule

// File: rtl/mw_master.sv
module mw_master
    import mw_pkg::*;
#(
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 4,
    parameter int DIV_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_push,
    input  logic [CMD_W-1:0]    tx_data,
    output logic                tx_full,
    input  logic                rx_pop,
    output logic [MAX_RESP-1:0] rx_data,
    output logic                rx_empty,
    input  logic [LEN_W-1:0]    resp_len,
    input  logic [DIV_W-1:0]    half_period,
    output logic                overrun,
    output logic                sclk,
    output logic                cs_n,
    output logic                mosi,
    input  logic                miso
);
    logic               tx_empty, tx_pop, rx_full, rx_push, run, tick;
    logic [CMD_W-1:0]   tx_head;
    logic [MAX_RESP-1:0] rx_word;

    mw_fifo #(.WIDTH(CMD_W), .DEPTH(TX_DEPTH)) i_tx_q (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .din(tx_data),
        .pop(tx_pop), .dout(tx_head), .full(tx_full), .empty(tx_empty)
    );

    mw_fifo #(.WIDTH(MAX_RESP), .DEPTH(RX_DEPTH)) i_rx_q (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_word),
        .pop(rx_pop), .dout(rx_data), .full(rx_full), .empty(rx_empty)
    );

    mw_divider #(.DIV_W(DIV_W)) i_div (
        .clk(clk), .rst_n(rst_n), .run(run), .half_in(half_period), .tick(tick)
    );

    mw_engine i_eng (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .tx_valid(!tx_empty), .tx_byte(tx_head), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_push(rx_push), .rx_word(rx_word),
        .resp_len(resp_len), .run(run), .overrun(overrun),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    assert_start_needs_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(!tx_empty));
endmodule

// File: tb/test_mw_master.sv
module test_mw_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_push = 1'b0;
    logic [7:0]  tx_data = '0;
    logic        tx_full;
    logic        rx_pop = 1'b0;
    logic [31:0] rx_data;
    logic        rx_empty;
    logic [5:0]  resp_len = 6'd8;
    logic [7:0]  half_period = 8'd1;
    logic        overrun;
    logic        sclk, cs_n, mosi;
    logic        miso = 1'b0;

    always #5 clk = ~clk;

    mw_master i_mw_master (
        .clk(clk), .rst_n(rst_n), .tx_push(tx_push), .tx_data(tx_data),
        .tx_full(tx_full), .rx_pop(rx_pop), .rx_data(rx_data), .rx_empty(rx_empty),
        .resp_len(resp_len), .half_period(half_period), .overrun(overrun),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    int total = 0;
    int bad   = 0;
    int h_eff = 1;
    int r_eff = 8;
    logic [7:0] exp_cmd [16];
    int n_exp = 0;
    int f_idx = 0;
    int frames_done = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [31:0] resp_of(input logic [7:0] c);
        return {c ^ 8'hA5, c, ~c, c + 8'd3};
    endfunction

    function automatic logic [31:0] word_of(input logic [7:0] c, input int r);
        logic [31:0] m;
        m = (r >= 32) ? 32'hFFFF_FFFF : ((32'd1 << r) - 32'd1);
        return resp_of(c) & m;
    endfunction

    function automatic int clamp(input int r);
        return (r < 4) ? 4 : ((r > 32) ? 32 : r);
    endfunction

    // Slave model, evaluated half a system cycle after each active edge.
    logic       prev_s = 1'b0, prev_c = 1'b1;
    int         k = 0, t = 0;
    logic [7:0] sh = '0, cur = '0;
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_s = 1'b0; prev_c = 1'b1; k = 0; t = 0; miso = 1'b0;
        end else begin
            t++;
            if (prev_c && !cs_n) begin
                t = 0; k = 0;
                check(mosi == exp_cmd[f_idx][7] && !sclk, "R2 first bit at select", mosi, exp_cmd[f_idx][7]);
            end else if (!cs_n && sclk && !prev_s) begin
                check(t == h_eff, "R3 rise spacing", t, h_eff);
                t = 0; k++;
                if (k <= 8) sh = {sh[6:0], mosi};
                if (k == 8) begin
                    check(sh == exp_cmd[f_idx], "R11 R2 command order", sh, exp_cmd[f_idx]);
                    cur = sh; f_idx++;
                end
                if (k == 9) check(mosi == 1'b0, "R4 wait clock", mosi, 0);
                if (k == 9 + r_eff) begin frames_done++; k = 0; end
            end else if (!cs_n && !sclk && prev_s) begin
                check(t == h_eff, "R3 fall spacing", t, h_eff);
                t = 0;
                if (k >= 9) miso = resp_of(cur)[r_eff - 1 - (k - 9)];
                else if (k == 0) begin
                    if (f_idx < n_exp) begin
                        check(mosi == exp_cmd[f_idx][7], "R8 chained MSB", mosi, exp_cmd[f_idx][7]);
                        check(!rx_empty, "R8 word pushed at chain edge", rx_empty, 0);
                    end else begin
                        check(mosi == 1'b0, "R7 mosi low before release", mosi, 0);
                    end
                end
            end else if (!prev_c && cs_n) begin
                check(t == h_eff && k == 0, "R7 release timing", t, h_eff);
                check(!rx_empty, "R7 word present at release", rx_empty, 0);
                check(!sclk && !mosi, "R1 idle after frame", {sclk, mosi}, 0);
            end
            prev_s = sclk; prev_c = cs_n;
        end
    end

    task automatic push_batch(input int n, input logic [7:0] base);
        n_exp = n; f_idx = 0; frames_done = 0;
        for (int i = 0; i < n; i++) exp_cmd[i] = base + 8'(i * 37);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tx_push = 1'b1; tx_data = exp_cmd[i];
        end
        @(negedge clk); tx_push = 1'b0;
        while (!(frames_done == n && cs_n)) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic pop_check(input logic [7:0] c, input string req);
        logic [31:0] e;
        e = word_of(c, r_eff);
        check(!rx_empty && rx_data == e, req, rx_data, e);
        rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0; @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(sclk == 0 && cs_n == 1 && mosi == 0 && rx_empty && !overrun, "R1 reset state",
              {sclk, cs_n, mosi}, 3'b010);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        check(cs_n == 1'b1 && sclk == 1'b0, "R10 no frame with empty queue", cs_n, 1);

        // Sweep: half periods 0..3 against lengths inside and outside 4..32.
        for (int h = 0; h < 4; h++) begin
            for (int j = 0; j < 16; j++) begin
                int rl;
                case (j)
                    0: rl = 0;   1: rl = 2;   2: rl = 3;   3: rl = 4;
                    4: rl = 5;   5: rl = 7;   6: rl = 8;   7: rl = 12;
                    8: rl = 16;  9: rl = 17;  10: rl = 24; 11: rl = 31;
                    12: rl = 32; 13: rl = 33; 14: rl = 40; default: rl = 63;
                endcase
                half_period = 8'(h);
                resp_len = 6'(rl);
                h_eff = (h == 0) ? 1 : h;
                r_eff = clamp(rl);
                push_batch(1, 8'(h * 64 + j * 13 + 1));
                pop_check(exp_cmd[0], (rl < 4 || rl > 32) ? "R5 clamped length word" : "R6 reply word");
                check(rx_empty, "R11 queue drained", rx_empty, 1);
            end
        end

        // Back-to-back frames.
        half_period = 8'd2; resp_len = 6'd13; h_eff = 2; r_eff = 13;
        push_batch(3, 8'h5C);
        for (int i = 0; i < 3; i++) pop_check(exp_cmd[i], "R8 chained word order");
        half_period = 8'd1; resp_len = 6'd32; h_eff = 1; r_eff = 32;
        push_batch(4, 8'h81);
        for (int i = 0; i < 4; i++) pop_check(exp_cmd[i], "R8 chained full length");

        // Overrun: fill the reply queue, then complete two more replies.
        begin
            logic [7:0] keep [4];
            resp_len = 6'd4; r_eff = 4;
            push_batch(4, 8'h10);
            for (int i = 0; i < 4; i++) keep[i] = exp_cmd[i];
            check(!overrun, "R9 no overrun yet", overrun, 0);
            push_batch(2, 8'hE0);
            check(overrun, "R9 overrun set", overrun, 1);
            for (int i = 0; i < 4; i++) pop_check(keep[i], "R9 kept words intact");
            check(rx_empty, "R9 dropped words absent", rx_empty, 1);
            repeat (20) @(negedge clk);
            check(overrun, "R9 overrun sticky", overrun, 1);
            check(cs_n && !sclk && !mosi, "R1 idle at end", {cs_n, sclk, mosi}, 3'b100);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule